// File: doc/BRIEF.md
# Peripheral Bus Address Demultiplexer

This block connects the data port of a small processor core to a set of memory-mapped slaves: a data RAM, a timer, a serial port, a loader and an output register. The address, write data and byte enables are a broadcast group. They are wired to every slave unchanged and are never gated. The handshake group (request, write enable, grant, read valid, read data, error) is switched. Each slave sees its forward control only when the address falls inside that slave's region. Only the selected slave's return signals reach the core. The returns of every other slave are forced to zero before they are combined.

The regions are packed back to back. The first region starts at `START_ADDR`, and each following region starts where the previous one ends. Region sizes are a parameter vector, so adding a slave means adding one size entry and widening the port vectors. The forward path is purely combinational.

A request to an address outside every region is not lost. The block grants it in the same cycle and answers one cycle later with read valid and error both high. That answer carries zero read data. This single-cycle error answer is the only register in the block.

Top module: `periph_addr_demux`

## Requirements
- R1: `slv_addr`, `slv_wdata` and `slv_be` always equal `core_addr`, `core_wdata` and `core_be`, whatever the request and address.
- R2: `slv_req[i]` is high exactly when `core_req` is high and base_i <= `core_addr` < base_i + size_i. With the default parameters the regions are:
  - slave 0: 0x0000–0x1FFF
  - slave 1: 0x2000–0x201F
  - slave 2: 0x2020–0x203F
  - slave 3: 0x2040–0x205F
  - slave 4: 0x2060–0x207F
- R3: `slv_we[i]` equals `core_we` ANDed with slave i's address match, and does not depend on `core_req`.
- R4: At most one bit of `slv_req` is high in any cycle.
- R5: `core_gnt`, `core_rvalid` and `core_err` carry the corresponding bit of the slave whose region holds `core_addr`. The same bits from all other slaves have no effect on them.
- R6: `core_rdata` equals the `slv_rdata` word (bits i*DW and up) of the slave whose region holds `core_addr`, and is zero when no region holds it.
- R7: A request to an address in no region raises `core_gnt` in the same cycle and raises no `slv_req` bit.
- R8: In the cycle after such an unmapped request, `core_rvalid` and `core_err` are high. While the address is still unmapped, `core_rdata` is zero.
- R9: An active-low `rst_n` asynchronously clears a pending unmapped-address answer. Holding reset with all slave returns zero gives `core_rvalid` = 0 and `core_err` = 0.
- R10: Region edges are exact:
  - the last byte of one region and the first byte of the next select different slaves;
  - 0x2080 (one past the last region) is unmapped;
  - 0xFFFFFFFF is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core request |
| core_we | input | 1 | Core write enable |
| core_be | input | DW/8 | Core byte enables |
| core_addr | input | AW | Core byte address |
| core_wdata | input | DW | Core write data |
| core_gnt | output | 1 | Grant to core |
| core_rvalid | output | 1 | Response valid to core |
| core_rdata | output | DW | Read data to core |
| core_err | output | 1 | Error response to core |
| slv_addr | output | AW | Broadcast address |
| slv_wdata | output | DW | Broadcast write data |
| slv_be | output | DW/8 | Broadcast byte enables |
| slv_req | output | NSLV | Per-slave request |
| slv_we | output | NSLV | Per-slave write enable |
| slv_gnt | input | NSLV | Per-slave grant |
| slv_rvalid | input | NSLV | Per-slave response valid |
| slv_rdata | input | NSLV*DW | Per-slave read data, slave i at bits i*DW and up |
| slv_err | input | NSLV | Per-slave error |

## Verification
The hardest situation to bring about is an unmapped-address answer overlapping new traffic. The registered error answer lands in the same cycle that a following access drives fresh addresses, and unrelated slaves drive random return bits. The stimulus therefore gives every slave random grant, valid, error and data values on every cycle. It mixes unmapped addresses into a random stream aimed mostly at the mapped window, so an error answer often coincides with a mapped or idle access. A directed sequence places addresses on every region edge. Another directed sequence asserts reset while an error answer is pending.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
   localparam int unsigned PBD_BYTE_W = 8;

   // true when the packed span [0, total) fits in an aw-bit byte address space
   function automatic bit pbd_span_fits(input longint unsigned total, input int aw);
      if (aw >= 63) return 1'b1;
      return total <= (64'd1 << aw);
   endfunction
endpackage

// File: rtl/pbd_region_decode.sv
module pbd_region_decode #(
   parameter int unsigned AW = 32,
   parameter int unsigned NSLV = 5,
   parameter logic [AW-1:0] START_ADDR = '0,
   parameter logic [NSLV-1:0][AW-1:0] REGION_SIZE = '0
) (
   input  logic [AW-1:0]   addr,
   output logic [NSLV-1:0] sel
);
   function automatic logic [AW:0] base_of(input int k);
      logic [AW:0] acc;
      acc = {1'b0, START_ADDR};
      for (int j = 0; j < int'(NSLV); j++) begin
         if (j < k) acc = acc + {1'b0, REGION_SIZE[j]};
      end
      return acc;
   endfunction

   localparam logic [AW:0] MAP_END = base_of(int'(NSLV));

   if (!pbd_pkg::pbd_span_fits(64'(MAP_END), int'(AW))) begin : g_bad_span
      $error("pbd_region_decode: regions run past the address space");
   end

   logic [AW:0] addr_w;
   assign addr_w = {1'b0, addr};

   for (genvar g = 0; g < int'(NSLV); g++) begin : g_region
      localparam logic [AW:0] BASE = base_of(g);
      localparam logic [AW:0] SIZE = {1'b0, REGION_SIZE[g]};
      if (REGION_SIZE[g] == '0) begin : g_bad_size
         $error("pbd_region_decode: region size must be nonzero");
      end
      logic [AW:0] offset;
      assign offset = addr_w - BASE;
      assign sel[g] = (addr_w >= BASE) && (offset < SIZE);
   end
endmodule

// File: rtl/pbd_return_mux.sv
module pbd_return_mux #(
   parameter int unsigned DW = 32,
   parameter int unsigned NSLV = 5
) (
   input  logic [NSLV-1:0]    sel,
   input  logic [NSLV-1:0]    gnt_in,
   input  logic [NSLV-1:0]    rvalid_in,
   input  logic [NSLV-1:0]    err_in,
   input  logic [NSLV*DW-1:0] rdata_in,
   output logic               gnt_out,
   output logic               rvalid_out,
   output logic               err_out,
   output logic [DW-1:0]      rdata_out
);
   always_comb begin
      gnt_out    = 1'b0;
      rvalid_out = 1'b0;
      err_out    = 1'b0;
      rdata_out  = '0;
      for (int i = 0; i < int'(NSLV); i++) begin
         gnt_out    = gnt_out    | (gnt_in[i]    & sel[i]);
         rvalid_out = rvalid_out | (rvalid_in[i] & sel[i]);
         err_out    = err_out    | (err_in[i]    & sel[i]);
         rdata_out  = rdata_out  | (rdata_in[i*DW +: DW] & {DW{sel[i]}});
      end
   end
endmodule

// File: rtl/pbd_unmapped_resp.sv
module pbd_unmapped_resp (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic any_sel,
   output logic miss_now,
   output logic miss_q
);
   assign miss_now = req & ~any_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miss_q <= 1'b0;
      else        miss_q <= miss_now;
   end
endmodule

// File: rtl/periph_addr_demux.sv
module periph_addr_demux #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter int unsigned NSLV = 5,
   parameter logic [AW-1:0] START_ADDR = '0,
   parameter logic [NSLV-1:0][AW-1:0] REGION_SIZE =
      {32'h20, 32'h20, 32'h20, 32'h20, 32'h2000}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  core_req,
   input  logic                  core_we,
   input  logic [DW/8-1:0]       core_be,
   input  logic [AW-1:0]         core_addr,
   input  logic [DW-1:0]         core_wdata,
   output logic                  core_gnt,
   output logic                  core_rvalid,
   output logic [DW-1:0]         core_rdata,
   output logic                  core_err,
   output logic [AW-1:0]         slv_addr,
   output logic [DW-1:0]         slv_wdata,
   output logic [DW/8-1:0]       slv_be,
   output logic [NSLV-1:0]       slv_req,
   output logic [NSLV-1:0]       slv_we,
   input  logic [NSLV-1:0]       slv_gnt,
   input  logic [NSLV-1:0]       slv_rvalid,
   input  logic [NSLV*DW-1:0]    slv_rdata,
   input  logic [NSLV-1:0]       slv_err
);
   if (NSLV < 1) begin : g_bad_nslv
      $error("periph_addr_demux: need at least one slave");
   end
   if (DW % pbd_pkg::PBD_BYTE_W != 0) begin : g_bad_dw
      $error("periph_addr_demux: data width must be whole bytes");
   end

   logic [NSLV-1:0] region_sel;
   logic            miss_now, miss_q;
   logic            mux_gnt, mux_rvalid, mux_err;

   // broadcast group
   assign slv_addr  = core_addr;
   assign slv_wdata = core_wdata;
   assign slv_be    = core_be;

   pbd_region_decode #(
      .AW(AW), .NSLV(NSLV), .START_ADDR(START_ADDR), .REGION_SIZE(REGION_SIZE)
   ) u_decode (
      .addr(core_addr),
      .sel (region_sel)
   );

   // switched forward group
   assign slv_req = region_sel & {NSLV{core_req}};
   assign slv_we  = region_sel & {NSLV{core_we}};

   pbd_return_mux #(.DW(DW), .NSLV(NSLV)) u_ret (
      .sel       (region_sel),
      .gnt_in    (slv_gnt),
      .rvalid_in (slv_rvalid),
      .err_in    (slv_err),
      .rdata_in  (slv_rdata),
      .gnt_out   (mux_gnt),
      .rvalid_out(mux_rvalid),
      .err_out   (mux_err),
      .rdata_out (core_rdata)
   );

   pbd_unmapped_resp u_miss (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (core_req),
      .any_sel (|region_sel),
      .miss_now(miss_now),
      .miss_q  (miss_q)
   );

   assign core_gnt    = mux_gnt | miss_now;
   assign core_rvalid = mux_rvalid | miss_q;
   assign core_err    = mux_err | miss_q;
endmodule

// File: rtl/periph_addr_demux_chk.sv
module periph_addr_demux_chk #(
   parameter int unsigned DW = 32,
   parameter int unsigned NSLV = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            core_req,
   input logic            core_gnt,
   input logic            core_rvalid,
   input logic            core_err,
   input logic [DW-1:0]   core_rdata,
   input logic [NSLV-1:0] slv_req,
   input logic [NSLV-1:0] slv_we,
   input logic [NSLV-1:0] region_sel
);
   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slv_req)); // R4
   AST_ONE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slv_we)); // R3
   AST_REQ_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (|slv_req) |-> core_req); // R2
   AST_MISS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !(|region_sel)) |-> core_gnt); // R7
   AST_MISS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !(|region_sel)) |=> (core_rvalid && core_err)); // R8
   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !(|region_sel) |-> (core_rdata == '0)); // R6
endmodule

bind periph_addr_demux periph_addr_demux_chk #(.DW(DW), .NSLV(NSLV)) u_chk (
   .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_gnt(core_gnt),
   .core_rvalid(core_rvalid), .core_err(core_err), .core_rdata(core_rdata),
   .slv_req(slv_req), .slv_we(slv_we), .region_sel(region_sel)
);

// File: tb/periph_addr_demux_bench.sv
`timescale 1ns/1ps
module periph_addr_demux_bench;
   localparam int N = 5;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_req = 0, core_we = 0;
   logic [3:0] core_be = '0;
   logic [31:0] core_addr = '0, core_wdata = '0;
   logic core_gnt, core_rvalid, core_err;
   logic [31:0] core_rdata;
   logic [31:0] slv_addr, slv_wdata;
   logic [3:0] slv_be;
   logic [N-1:0] slv_req, slv_we;
   logic [N-1:0] slv_gnt = '0, slv_rvalid = '0, slv_err = '0;
   logic [N*DW-1:0] slv_rdata = '0;

   int nchk = 0, nerr = 0;
   bit prev_miss = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   periph_addr_demux u_periph_addr_demux (.*);

   // region index from the requirement map; N means unmapped
   function automatic int exp_idx(input logic [31:0] a);
      if (a < 32'h2000) return 0;
      if (a < 32'h2020) return 1;
      if (a < 32'h2040) return 2;
      if (a < 32'h2060) return 3;
      if (a < 32'h2080) return 4;
      return N;
   endfunction

   task automatic check(input string tg, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] a, input logic rq, input logic w, input string tg);
      int idx;
      logic [N-1:0] e_req, e_we;
      logic e_gnt, e_rv, e_err;
      logic [31:0] e_rd;
      @(negedge clk);
      core_addr = a; core_req = rq; core_we = w;
      core_be = 4'($urandom); core_wdata = $urandom;
      slv_gnt = N'($urandom); slv_rvalid = N'($urandom); slv_err = N'($urandom);
      for (int k = 0; k < N; k++) slv_rdata[k*DW +: DW] = $urandom;
      #1;
      idx = exp_idx(a);
      e_req = '0; e_we = '0; e_gnt = 0; e_rv = 0; e_err = 0; e_rd = '0;
      if (idx < N) begin
         e_req[idx] = rq; e_we[idx] = w;
         e_gnt = slv_gnt[idx]; e_rv = slv_rvalid[idx]; e_err = slv_err[idx];
         e_rd = slv_rdata[idx*DW +: DW];
      end else begin
         e_gnt = rq;
      end
      e_rv = e_rv | prev_miss;
      e_err = e_err | prev_miss;
      check("R1 addr", 64'(slv_addr), 64'(a));
      check("R1 wdata", 64'(slv_wdata), 64'(core_wdata));
      check("R1 be", 64'(slv_be), 64'(core_be));
      check(tg, 64'(slv_req), 64'(e_req));
      check("R4 onehot", 64'($countones(slv_req) <= 1), 64'd1);
      check("R3 we", 64'(slv_we), 64'(e_we));
      check(idx < N ? "R5 gnt" : "R7 gnt", 64'(core_gnt), 64'(e_gnt));
      check(prev_miss ? "R8 rvalid" : "R5 rvalid", 64'(core_rvalid), 64'(e_rv));
      check(prev_miss ? "R8 err" : "R5 err", 64'(core_err), 64'(e_err));
      check(idx < N ? "R6 rdata" : "R8 rdata", 64'(core_rdata), 64'(e_rd));
      prev_miss = rq && (idx == N);
      @(posedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed1234));
      // reset state
      #1;
      check("R9 rvalid in reset", 64'(core_rvalid), 64'd0);
      check("R9 err in reset", 64'(core_err), 64'd0);
      check("R2 req in reset", 64'(slv_req), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // region edges
      step(32'h0000_0000, 1, 0, "R10 first byte slave0");
      step(32'h0000_1FFF, 1, 1, "R10 last byte slave0");
      step(32'h0000_2000, 1, 0, "R10 first byte slave1");
      step(32'h0000_201F, 1, 1, "R10 last byte slave1");
      step(32'h0000_2020, 1, 0, "R10 first byte slave2");
      step(32'h0000_205F, 1, 0, "R10 last byte slave3");
      step(32'h0000_2060, 1, 1, "R10 first byte slave4");
      step(32'h0000_207F, 1, 0, "R10 last byte slave4");
      step(32'h0000_2080, 1, 0, "R10 one past map");
      step(32'h0000_2080, 0, 0, "R8 idle after miss");
      step(32'hFFFF_FFFF, 1, 1, "R10 top address");
      step(32'h0000_2000, 1, 0, "R8 miss then mapped");
      step(32'h0000_2040, 0, 1, "R3 we without req");

      // reset clears a pending unmapped answer
      step(32'h0001_0000, 1, 0, "R7 miss before reset");
      @(negedge clk);
      core_req = 0; slv_gnt = '0; slv_rvalid = '0; slv_err = '0;
      #1;
      check("R8 pending answer", 64'(core_rvalid & core_err), 64'd1);
      rst_n = 1'b0;
      #1;
      check("R9 rvalid cleared", 64'(core_rvalid), 64'd0);
      check("R9 err cleared", 64'(core_err), 64'd0);
      prev_miss = 0;
      @(negedge clk); rst_n = 1'b1;

      // constrained random
      for (int it = 0; it < 600; it++) begin
         logic [31:0] a;
         int pick;
         pick = int'($urandom % 8);
         if (pick < 5)       a = 32'($urandom % 32'h2100);
         else if (pick == 5) a = 32'h2000 + 32'($urandom % 32'h100);
         else                a = $urandom;
         step(a, 1'($urandom), 1'($urandom), "R2 random decode");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule